// File: doc/BRIEF.md
# Sorted-Delta Four-Channel Pulse Scheduler

This block drives four servo-style pulse outputs from one shared frame timer and one compare point. All outputs rise together when a frame starts. Each output then falls at its own programmed width. The widths are counted in ticks, and one tick is a fixed number of clock cycles.

At every frame start the block copies the clamped widths and builds a linked list sorted by end time. Each list node holds the number of ticks between its own end time and the end time of the node before it. A single compare against the end time of the list head then retires the channels in order. When several nodes carry a zero delta, all of those channels fall on the same clock edge. After that the compare moves to the next remaining end time. When the list is empty, the block waits for the next frame.

Top module: `pwm_dq_sched`

## Requirements
- R1: While `rst` is high, all outputs are low. The first frame starts on the first rising clock edge after `rst` is released, and all outputs are high after that edge.
- R2: One tick is `TICK_DIV` clock cycles. Frame starts occur every `FRAME * TICK_DIV` clock cycles.
- R3: At a frame start all four outputs rise on the same edge. An output never rises at any other time.
- R4: Channel i takes its width from bits [i*WW +: WW] of `wid_i`. Its output stays high for exactly (clamped width) × `TICK_DIV` clock cycles after the frame start.
- R5: Channels with equal clamped widths fall on the same clock edge.
- R6: Channels fall in ascending order of width. For example, widths 1573, 2000, 1206 and 1573 on channels 0 to 3 make channel 2 fall first, then channels 0 and 3 together, then channel 1.
- R7: A change of `wid_i` in the middle of a frame has no effect on that frame. It takes effect at the next frame start.
- R8: A width below `MIN_W` is treated as `MIN_W`. A width above `FRAME-1` is treated as `FRAME-1`.
- R9: Building the sorted list finishes before the tick count reaches `MIN_W`.
- R10: Every pulse has ended by the last tick of its frame, so all outputs are low when the next frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wid_i | input | NCH*WW | Packed per-channel pulse widths in ticks |
| pwm_o | output | NCH | Registered pulse outputs, one per channel |

## Verification
The first width set is the four-channel example from R6. It contains one tie, one value below the tie and one value above it, so a single frame shows whether insertion places the entry correctly and whether the zero-delta entry retires in the same event. A set where all four widths are equal shows whether a chain of several zero deltas is walked in one event. A clamping set and an ascending set check R8 and R4 at the extremes. Changing the widths in the middle of a frame shows that the snapshot is taken only at frame start.

// File: rtl/pwm_dq_pkg.sv
package pwm_dq_pkg;
  typedef enum logic [0:0] {
    BLD_IDLE = 1'b0,
    BLD_WALK = 1'b1
  } bld_state_t;
endpackage

// File: rtl/pwm_dq_timer.sv
module pwm_dq_timer #(
  parameter int FRAME    = 20000,
  parameter int TICK_DIV = 1,
  localparam int CW = $clog2(FRAME),
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic          tick_o,
  output logic          frame_go_o,
  output logic [CW-1:0] cnt_o
);
  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  assign tick_o     = (pre_q == PW'(TICK_DIV - 1));
  assign frame_go_o = tick_o && (cnt_q == CW'(FRAME - 1));
  assign cnt_o      = cnt_q;

  // Reset parks both counters at their last value so that the first
  // clock edge after reset begins a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= PW'(TICK_DIV - 1);
      cnt_q <= CW'(FRAME - 1);
    end else if (tick_o) begin
      pre_q <= '0;
      cnt_q <= frame_go_o ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(FRAME));
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    frame_go_o |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_dq_list.sv
module pwm_dq_list
  import pwm_dq_pkg::*;
#(
  parameter int NCH = 4,
  parameter int WW  = 16,
  localparam int IW = $clog2(NCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NCH*WW-1:0] wid_i,
  input  logic             pop_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [WW-1:0]    head_end_o,
  output logic [NCH-1:0]   drop_o
);
  // Node 0 is the list head. Node n (1..NCH) stands for channel n-1.
  logic [IW-1:0] nxt_q [0:NCH];
  logic [IW-1:0] prv_q [0:NCH];
  logic [WW-1:0] dlt_q [0:NCH];
  logic [WW-1:0] end_q [0:NCH];

  bld_state_t    st_q;
  logic          built_q;
  logic [IW-1:0] node_q, cur_q;
  logic [WW-1:0] key_q;

  // One walk step of the insertion sort.
  logic [IW-1:0] wnx;
  logic          wadv;
  assign wnx  = nxt_q[cur_q];
  assign wadv = (wnx != '0) && (dlt_q[wnx] <= key_q);

  // Retirement: the head node plus every zero-delta node that follows it.
  logic [NCH:0]  dropn;
  logic [IW-1:0] newh;
  always_comb begin
    logic [IW-1:0] m;
    logic          go;
    dropn = '0;
    m     = nxt_q[0];
    if (m != '0) dropn[m] = 1'b1;
    m  = nxt_q[m];
    go = 1'b1;
    for (int i = 1; i < NCH; i++) begin
      if (go && (m != '0) && (dlt_q[m] == '0)) begin
        dropn[m] = 1'b1;
        m        = nxt_q[m];
      end else begin
        go = 1'b0;
      end
    end
    newh = m;
  end

  assign drop_o     = dropn[NCH:1];
  assign busy_o     = (st_q == BLD_WALK);
  assign valid_o    = built_q && (nxt_q[0] != '0);
  assign head_end_o = end_q[nxt_q[0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= BLD_IDLE;
      built_q <= 1'b0;
      node_q  <= '0;
      cur_q   <= '0;
      key_q   <= '0;
      for (int n = 0; n <= NCH; n++) begin
        nxt_q[n] <= '0;
        prv_q[n] <= '0;
        dlt_q[n] <= '0;
        end_q[n] <= '0;
      end
    end else if (start_i) begin
      st_q     <= BLD_WALK;
      built_q  <= 1'b0;
      nxt_q[0] <= '0;
      prv_q[0] <= '0;
      node_q   <= IW'(1);
      cur_q    <= '0;
      key_q    <= wid_i[0 +: WW];
      for (int n = 1; n <= NCH; n++) end_q[n] <= wid_i[(n-1)*WW +: WW];
    end else if (st_q == BLD_WALK) begin
      if (wadv) begin
        key_q <= key_q - dlt_q[wnx];
        cur_q <= wnx;
      end else begin
        dlt_q[node_q] <= key_q;
        nxt_q[node_q] <= wnx;
        prv_q[node_q] <= cur_q;
        nxt_q[cur_q]  <= node_q;
        if (wnx != '0) begin
          dlt_q[wnx] <= dlt_q[wnx] - key_q;
          prv_q[wnx] <= node_q;
        end
        if (node_q == IW'(NCH)) begin
          st_q    <= BLD_IDLE;
          built_q <= 1'b1;
        end else begin
          node_q <= node_q + 1'b1;
          cur_q  <= '0;
          key_q  <= end_q[node_q + 1'b1];
        end
      end
    end else if (pop_i && valid_o) begin
      nxt_q[0] <= newh;
      if (newh != '0) prv_q[newh] <= '0;
    end
  end

  p_sorted_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (pop_i && valid_o && (newh != '0)) |=> (valid_o && (head_end_o >= $past(head_end_o))));
  p_head_backlink_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (prv_q[nxt_q[0]] == '0));
  p_pop_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && valid_o) |-> (drop_o != '0));
endmodule

// File: rtl/pwm_dq_sched.sv
module pwm_dq_sched #(
  parameter int NCH      = 4,
  parameter int WW       = 16,
  parameter int FRAME    = 20000,
  parameter int TICK_DIV = 1,
  parameter int MIN_W    = 32,
  localparam int CW = $clog2(FRAME)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*WW-1:0] wid_i,
  output logic [NCH-1:0]    pwm_o
);
  logic          tick, frame_go;
  logic [CW-1:0] cnt;
  logic [NCH*WW-1:0] wid_c;
  logic          busy, valid, hit;
  logic [WW-1:0] head_end;
  logic [NCH-1:0] drop;
  logic [NCH-1:0] pwm_q;

  pwm_dq_timer #(.FRAME(FRAME), .TICK_DIV(TICK_DIV)) u_tmr (
    .clk(clk), .rst(rst), .tick_o(tick), .frame_go_o(frame_go), .cnt_o(cnt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_clamp
    logic [WW-1:0] w;
    assign w = wid_i[g*WW +: WW];
    assign wid_c[g*WW +: WW] = (w < WW'(MIN_W))     ? WW'(MIN_W) :
                               (w > WW'(FRAME - 1)) ? WW'(FRAME - 1) : w;
  end

  pwm_dq_list #(.NCH(NCH), .WW(WW)) u_list (
    .clk(clk), .rst(rst), .start_i(frame_go), .wid_i(wid_c), .pop_i(hit),
    .busy_o(busy), .valid_o(valid), .head_end_o(head_end), .drop_o(drop)
  );

  // The match is taken on the tick that moves the count onto the end time.
  assign hit = tick && valid && ((WW+1)'(cnt) + 1'b1 == {1'b0, head_end});

  always_ff @(posedge clk) begin
    if (rst)           pwm_q <= '0;
    else if (frame_go) pwm_q <= '1;
    else if (hit)      pwm_q <= pwm_q & ~drop;
  end
  assign pwm_o = pwm_q;

  p_rise_together_r3: assert property (@(posedge clk) disable iff (rst)
    frame_go |=> (pwm_o == '1));
  p_rise_only_at_frame_r3: assert property (@(posedge clk) disable iff (rst)
    (|(pwm_o & ~$past(pwm_o))) |-> $past(frame_go));
  p_build_in_time_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((WW+1)'(cnt) < (WW+1)'(MIN_W)));
  p_all_done_r10: assert property (@(posedge clk) disable iff (rst)
    frame_go |-> (pwm_o == '0));
endmodule

// File: tb/sim_pwm_dq_sched.sv
module sim_pwm_dq_sched;
  localparam int NCH = 4, WW = 16, FRAME = 2500, TD = 2, MIN_W = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [NCH*WW-1:0] wid = '0;
  logic [NCH-1:0] pwm;
  int checks = 0, bad = 0, cyc = 0, last_rise = 0;
  int hi [NCH];
  int fk [NCH];

  always #5 clk = ~clk;
  always @(negedge clk) cyc++;

  pwm_dq_sched #(.NCH(NCH), .WW(WW), .FRAME(FRAME), .TICK_DIV(TD), .MIN_W(MIN_W)) u0 (
    .clk(clk), .rst(rst), .wid_i(wid), .pwm_o(pwm)
  );

  function automatic int clampw(int w);
    return (w < MIN_W) ? MIN_W : (w > FRAME - 1) ? FRAME - 1 : w;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_w(int a, int b, int c, int d);
    wid = {WW'(d), WW'(c), WW'(b), WW'(a)};
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (pwm[0]);
    do @(negedge clk); while (!pwm[0]);
    last_rise = cyc;
  endtask

  // Measures one frame from its rise. When chg_at > 0, the widths are
  // rewritten that many cycles into the frame.
  task automatic measure(int chg_at, logic [NCH*WW-1:0] neww);
    int k;
    wait_rise();
    chk("R3 all rise together", int'(pwm), 15);
    for (int c = 0; c < NCH; c++) begin hi[c] = 1; fk[c] = 0; end
    k = 1;
    while (((fk[0] == 0) || (fk[1] == 0) || (fk[2] == 0) || (fk[3] == 0)) && k < FRAME*TD + 10) begin
      @(negedge clk);
      k++;
      if (k == chg_at) wid = neww;
      for (int c = 0; c < NCH; c++) begin
        if (fk[c] == 0) begin
          if (pwm[c]) hi[c]++;
          else fk[c] = k;
        end
      end
    end
  endtask

  task automatic check_widths(string req, int a, int b, int c, int d);
    chk(req, hi[0], clampw(a)*TD);
    chk(req, hi[1], clampw(b)*TD);
    chk(req, hi[2], clampw(c)*TD);
    chk(req, hi[3], clampw(d)*TD);
  endtask

  task automatic t_reset();
    set_w(1000, 1000, 1000, 1000);
    repeat (5) @(negedge clk);
    chk("R1 low in reset", int'(pwm), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 high after first edge", int'(pwm), 15);
    last_rise = cyc;
  endtask

  task automatic t_example();
    set_w(1573, 2000, 1206, 1573);
    measure(0, '0);
    check_widths("R4 example widths", 1573, 2000, 1206, 1573);
    chk("R5 tie falls together", fk[0], fk[3]);
    chk("R6 ch2 before ch0", int'(fk[2] < fk[0]), 1);
    chk("R6 ch0 before ch1", int'(fk[0] < fk[1]), 1);
  endtask

  task automatic t_period();
    int r1;
    wait_rise();
    r1 = last_rise;
    wait_rise();
    chk("R2 frame period", last_rise - r1, FRAME*TD);
  endtask

  task automatic t_equal();
    set_w(700, 700, 700, 700);
    measure(0, '0);
    check_widths("R4 equal widths", 700, 700, 700, 700);
    chk("R5 all equal fall 1", fk[1], fk[0]);
    chk("R5 all equal fall 2", fk[2], fk[0]);
    chk("R5 all equal fall 3", fk[3], fk[0]);
  endtask

  task automatic t_clamp();
    set_w(5, 3000, MIN_W, FRAME - 1);
    measure(0, '0);
    check_widths("R8 clamp", 5, 3000, MIN_W, FRAME - 1);
    chk("R8 low clamp equals MIN_W", hi[0], MIN_W*TD);
    chk("R10 max pulse ends in frame", hi[1], (FRAME - 1)*TD);
  endtask

  task automatic t_midframe();
    set_w(400, 500, 600, 700);
    measure(100, {WW'(1100), WW'(1000), WW'(900), WW'(800)});
    check_widths("R7 old widths kept", 400, 500, 600, 700);
    measure(0, '0);
    check_widths("R7 new widths next frame", 800, 900, 1000, 1100);
    chk("R6 ascending order", int'((fk[0] < fk[1]) && (fk[1] < fk[2]) && (fk[2] < fk[3])), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_period();
    t_equal();
    t_clamp();
    t_midframe();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule